// File: doc/BRIEF.md
# Index Prefix Operand Remapper

This decode-stage block sits in front of the operand-select logic of an 8-bit accumulator CPU that has two 16-bit index registers. It receives the instruction stream one byte at a time, keeps track of whether the current instruction carries an index prefix (0xDD selects the first index register, called X here, and 0xFD selects the second, called Y), and finds where each instruction ends. For each finished instruction it emits one strobe. The strobe carries the 8-bit operand selectors, with H, L and the memory operand redirected to the index halves or to an indexed address where the prefix applies. It also carries the collected displacement, the immediate bytes, and the resolved memory address.

Input bytes use a valid/ready handshake. `in_ready` is low during reset and stays high afterwards, so the block never applies back-pressure. A byte transfers on any rising edge where both `in_valid` and `in_ready` are high, and gaps with `in_valid` low are allowed. The decoded strobe `dec_valid` has no ready signal. It is high for exactly one cycle, and the consumer must take it in that cycle. Each prefix byte that a later prefix replaces, before the instruction arrives, also gets a strobe of its own, marked as a no-operation.

Top module: `idx_remap`

## Requirements
- R1: While `rst` is high, `dec_valid` and `in_ready` are low. `in_ready` is high from the first cycle after reset ends.
- R2: Without a prefix, `dec_idx` is 0 and `dec_pfx_nop` is 0. For a main-page instruction with an 8-bit register field, that field appears unchanged as its operand code: B=0, C=1, D=2, E=3, H=4, L=5, memory at HL=6, A=7. Bits 5:3 of the opcode drive `dec_dst` and bits 2:0 drive `dec_src`. A field that the instruction does not use reads 15.
- R3: Under a prefix that applies, `dec_idx` is 1 for 0xDD and 2 for 0xFD. The H and L fields become 8 and 9 (X) or 10 and 11 (Y), and the memory field becomes 12 (X+d) or 13 (Y+d).
- R4: When one field of an instruction is the memory operand and a prefix applies, only that field is remapped. A register field that names H or L in the same instruction keeps the code 4 or 5.
- R5: A prefix is dropped, with `dec_idx`=0 and `dec_pfx_nop`=1, in three cases: the main instruction touches none of H, L, HL or the memory field; the opcode is 0xEB or 0xD9; or the instruction is on the 0xED page. In these cases the operands decode exactly as they would without the prefix.
- R6: When a prefix byte is followed directly by another 0xDD or 0xFD, the earlier byte produces its own strobe with `dec_kind`=0, `dec_op` equal to that byte, `dec_pfx_nop`=1 and `dec_idx`=0. Only the final prefix applies to the instruction.
- R7: For an indexed memory operand, the byte right after the main opcode is the displacement and appears on `dec_disp`. Any immediate bytes follow the displacement and appear on `dec_imm`, low byte first. `dec_imm` reads 0 when there are no immediate bytes.
- R8: When `dec_mem` is 1, `dec_addr` is the index value plus the sign-extended displacement, modulo 65536, if a prefix applies; otherwise it is `hl_val`. When `dec_mem` is 0, `dec_addr` is 0.
- R9: In a prefixed 0xCB sequence, the byte after 0xCB is the displacement and the next byte is the final opcode. `dec_kind` is 2, `dec_src` is the indexed memory code, and `dec_dst` is that same code when opcode bits 2:0 are 6; otherwise `dec_dst` is the plain register code.
- R10: Instructions that use HL as a 16-bit pair (ADD HL,rr, LD HL,nn, INC/DEC HL, LD (nn),HL, LD HL,(nn), POP/PUSH HL, EX (SP),HL, JP (HL), LD SP,HL) take the prefix: `dec_idx` is non-zero and `dec_pfx_nop` is 0.
- R11: `dec_valid` rises in the cycle after the final byte of an instruction is accepted and stays high for one cycle. The prefix state is cleared once that instruction completes.
- R12: `dec_kind` is 1 for the main page, 2 for the 0xCB page and 3 for the 0xED page. The 0xED page takes two immediate bytes when opcode bits 7:6 are 01 and bits 2:0 are 011, and none otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte valid |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_byte | input | 8 | Instruction byte |
| hl_val | input | 16 | Current HL pair value |
| ix_val | input | 16 | Current X index value |
| iy_val | input | 16 | Current Y index value |
| dec_valid | output | 1 | One-cycle decoded strobe |
| dec_kind | output | 2 | 0 dropped prefix, 1 main, 2 bit page, 3 extended page |
| dec_op | output | 8 | Final opcode byte (prefix byte for kind 0) |
| dec_idx | output | 2 | Applied index: 0 none, 1 X, 2 Y |
| dec_pfx_nop | output | 1 | A prefix was seen but had no effect |
| dec_dst | output | 4 | Operand code for the destination field |
| dec_src | output | 4 | Operand code for the source field |
| dec_mem | output | 1 | Instruction has a memory operand |
| dec_addr | output | 16 | Memory operand address |
| dec_disp | output | 8 | Displacement byte when indexed |
| dec_imm | output | 16 | Immediate bytes, low byte first |

## Verification
The hardest case to reach is a chain of mixed prefixes in front of a bit-page sequence. In that case one input stream has to produce a dropped-prefix strobe, then a displacement taken before the opcode, then a destination copy that depends on the final opcode's low bits. The bench builds these chains byte by byte and checks every intermediate strobe. Address wrap at both ends of the 16-bit space is reached by running all 256 displacement values against index values placed near 0xFFFF and near 0x0000.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;
  localparam logic [7:0] PFX_X  = 8'hDD;
  localparam logic [7:0] PFX_Y  = 8'hFD;
  localparam logic [7:0] PG_BIT = 8'hCB;
  localparam logic [7:0] PG_EXT = 8'hED;

  localparam logic [1:0] IDX_NONE = 2'd0;
  localparam logic [1:0] IDX_X    = 2'd1;
  localparam logic [1:0] IDX_Y    = 2'd2;

  localparam logic [1:0] K_PFX  = 2'd0;
  localparam logic [1:0] K_MAIN = 2'd1;
  localparam logic [1:0] K_BIT  = 2'd2;
  localparam logic [1:0] K_EXT  = 2'd3;

  localparam logic [3:0] OPR_NONE = 4'd15;

  typedef enum logic [2:0] {
    ST_OP, ST_BITOP, ST_EXTOP, ST_XDISP, ST_XOP, ST_DISP, ST_IMM
  } st_e;

  typedef struct packed {
    logic       use_y;
    logic       use_z;
    logic       use_pair;
    logic [1:0] imm_n;
  } cls_t;
endpackage

// File: rtl/idx_remap_classify.sv
module idx_remap_classify
  import idx_remap_pkg::*;
(
  input  logic [7:0] op,
  input  logic       ext_page,
  output cls_t       cls
);
  logic [1:0] x;
  logic [2:0] y, z;
  assign x = op[7:6];
  assign y = op[5:3];
  assign z = op[2:0];

  always_comb begin
    cls = '0;
    if (ext_page) begin
      cls.imm_n = (x == 2'd1 && z == 3'd3) ? 2'd2 : 2'd0;
    end else begin
      case (x)
        2'd0: begin
          case (z)
            3'd0: cls.imm_n = (y >= 3'd2) ? 2'd1 : 2'd0;
            3'd1: begin
              if (y[0]) cls.use_pair = 1'b1;
              else begin
                cls.imm_n    = 2'd2;
                cls.use_pair = (y[2:1] == 2'd2);
              end
            end
            3'd2: begin
              cls.imm_n    = y[2] ? 2'd2 : 2'd0;
              cls.use_pair = (y[2:1] == 2'd2);
            end
            3'd3: cls.use_pair = (y[2:1] == 2'd2);
            3'd4, 3'd5: cls.use_y = 1'b1;
            3'd6: begin
              cls.use_y = 1'b1;
              cls.imm_n = 2'd1;
            end
            default: ;
          endcase
        end
        2'd1: begin
          cls.use_y = (op != 8'h76);
          cls.use_z = (op != 8'h76);
        end
        2'd2: cls.use_z = 1'b1;
        default: begin
          case (z)
            3'd1: cls.use_pair = (op == 8'hE1) || (op == 8'hE9) || (op == 8'hF9);
            3'd2, 3'd4: cls.imm_n = 2'd2;
            3'd3: begin
              cls.imm_n    = (y == 3'd0) ? 2'd2 :
                             (y == 3'd2 || y == 3'd3) ? 2'd1 : 2'd0;
              cls.use_pair = (op == 8'hE3);
            end
            3'd5: begin
              cls.use_pair = (op == 8'hE5);
              cls.imm_n    = (op == 8'hCD) ? 2'd2 : 2'd0;
            end
            3'd6: cls.imm_n = 2'd1;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/idx_remap_opmap.sv
module idx_remap_opmap
  import idx_remap_pkg::*;
(
  input  logic [2:0] fld,
  input  logic [1:0] idx,
  input  logic       keep_hl,
  output logic [3:0] code
);
  always_comb begin
    code = {1'b0, fld};
    if (idx != IDX_NONE) begin
      if (fld == 3'd6)
        code = {3'b110, idx == IDX_Y};
      else if (fld[2:1] == 2'b10 && !keep_hl)
        code = {2'b10, idx == IDX_Y, fld[0]};
    end
  end
endmodule

// File: rtl/idx_remap_addr.sv
module idx_remap_addr #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [7:0]    disp,
  output logic [AW-1:0] addr
);
  localparam int EXT_W = AW - 8;
  assign addr = base + {{EXT_W{disp[7]}}, disp};
endmodule

// File: rtl/idx_remap.sv
module idx_remap
  import idx_remap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] hl_val,
  input  logic [ADDR_W-1:0] ix_val,
  input  logic [ADDR_W-1:0] iy_val,
  output logic              dec_valid,
  output logic [1:0]        dec_kind,
  output logic [7:0]        dec_op,
  output logic [1:0]        dec_idx,
  output logic              dec_pfx_nop,
  output logic [3:0]        dec_dst,
  output logic [3:0]        dec_src,
  output logic              dec_mem,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [7:0]        dec_disp,
  output logic [15:0]       dec_imm
);
  st_e        state;
  logic [1:0] pfx_q;
  logic       ext_q, rdy_q, imm_pos_q;
  logic [7:0] op_q, disp_q, imm_lo_q;
  logic [1:0] imm_left_q;

  logic       acc, op_state, cur_ext, touch, mem_main, mem_any;
  logic [7:0] cur_op, disp_eff;
  logic [1:0] app_idx, cur_kind, fin_idx;
  cls_t       cls;
  logic [3:0] fmap [2];
  logic [3:0] fin_dst, fin_src, bit_mem;
  logic [ADDR_W-1:0] base, addr_idx, fin_addr;
  logic [7:0]  fin_disp;
  logic [15:0] fin_imm;

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;
  assign op_state = (state == ST_OP) || (state == ST_EXTOP) ||
                    (state == ST_BITOP) || (state == ST_XOP);
  assign cur_op   = op_state ? in_byte : op_q;
  assign cur_ext  = (state == ST_EXTOP) || ext_q;

  idx_remap_classify u_cls (.op(cur_op), .ext_page(cur_ext), .cls(cls));

  assign touch    = cls.use_pair ||
                    (cls.use_y && (cur_op[5:4] == 2'b10 || cur_op[5:3] == 3'd6)) ||
                    (cls.use_z && (cur_op[2:1] == 2'b10 || cur_op[2:0] == 3'd6));
  assign mem_main = (cls.use_y && cur_op[5:3] == 3'd6) || (cls.use_z && cur_op[2:0] == 3'd6);
  assign app_idx  = touch ? pfx_q : IDX_NONE;

  genvar g;
  for (g = 0; g < 2; g++) begin : g_fld
    idx_remap_opmap u_map (
      .fld     (g == 0 ? cur_op[5:3] : cur_op[2:0]),
      .idx     (app_idx),
      .keep_hl (mem_main),
      .code    (fmap[g])
    );
  end

  assign cur_kind = (state == ST_BITOP || state == ST_XOP) ? K_BIT :
                    cur_ext ? K_EXT : K_MAIN;
  assign disp_eff = (state == ST_DISP) ? in_byte : disp_q;
  assign bit_mem  = {3'b110, pfx_q == IDX_Y};

  always_comb begin
    case (cur_kind)
      K_BIT: begin
        fin_idx = pfx_q;
        mem_any = (cur_op[2:0] == 3'd6) || (pfx_q != IDX_NONE);
        fin_src = (pfx_q != IDX_NONE) ? bit_mem : {1'b0, cur_op[2:0]};
        fin_dst = (pfx_q != IDX_NONE && cur_op[2:0] == 3'd6) ? bit_mem : {1'b0, cur_op[2:0]};
      end
      K_EXT: begin
        fin_idx = IDX_NONE;
        mem_any = 1'b0;
        fin_src = OPR_NONE;
        fin_dst = OPR_NONE;
      end
      default: begin
        fin_idx = app_idx;
        mem_any = mem_main;
        fin_dst = cls.use_y ? fmap[0] : OPR_NONE;
        fin_src = cls.use_z ? fmap[1] : OPR_NONE;
      end
    endcase
  end

  assign base = (fin_idx == IDX_Y) ? iy_val : ix_val;
  idx_remap_addr #(.AW(ADDR_W)) u_addr (.base(base), .disp(disp_eff), .addr(addr_idx));

  assign fin_addr = !mem_any ? '0 : (fin_idx != IDX_NONE) ? addr_idx : hl_val;
  assign fin_disp = (mem_any && fin_idx != IDX_NONE) ? disp_eff : 8'h00;
  assign fin_imm  = (state != ST_IMM) ? 16'h0000 :
                    imm_pos_q ? {in_byte, imm_lo_q} : {8'h00, in_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OP;  pfx_q <= IDX_NONE;  ext_q <= 1'b0;  rdy_q <= 1'b0;
      op_q <= '0;  disp_q <= '0;  imm_lo_q <= '0;  imm_pos_q <= 1'b0;  imm_left_q <= '0;
      dec_valid <= 1'b0;  dec_kind <= K_PFX;  dec_op <= '0;  dec_idx <= IDX_NONE;
      dec_pfx_nop <= 1'b0;  dec_dst <= OPR_NONE;  dec_src <= OPR_NONE;  dec_mem <= 1'b0;
      dec_addr <= '0;  dec_disp <= '0;  dec_imm <= '0;
    end else begin
      logic emit;
      emit      = 1'b0;
      rdy_q     <= 1'b1;
      dec_valid <= 1'b0;
      if (acc) begin
        case (state)
          ST_OP: begin
            if (in_byte == PFX_X || in_byte == PFX_Y) begin
              if (pfx_q != IDX_NONE) begin
                dec_valid <= 1'b1;  dec_kind <= K_PFX;
                dec_op <= (pfx_q == IDX_X) ? PFX_X : PFX_Y;
                dec_idx <= IDX_NONE;  dec_pfx_nop <= 1'b1;
                dec_dst <= OPR_NONE;  dec_src <= OPR_NONE;  dec_mem <= 1'b0;
                dec_addr <= '0;  dec_disp <= '0;  dec_imm <= '0;
              end
              pfx_q <= (in_byte == PFX_X) ? IDX_X : IDX_Y;
            end else if (in_byte == PG_BIT) begin
              disp_q <= '0;
              state  <= (pfx_q != IDX_NONE) ? ST_XDISP : ST_BITOP;
            end else if (in_byte == PG_EXT) begin
              ext_q <= 1'b1;
              state <= ST_EXTOP;
            end else begin
              op_q <= in_byte;  disp_q <= '0;  imm_pos_q <= 1'b0;
              if (mem_main && app_idx != IDX_NONE) state <= ST_DISP;
              else if (cls.imm_n != 2'd0) begin
                imm_left_q <= cls.imm_n;  state <= ST_IMM;
              end else emit = 1'b1;
            end
          end
          ST_EXTOP: begin
            op_q <= in_byte;  imm_pos_q <= 1'b0;
            if (cls.imm_n != 2'd0) begin
              imm_left_q <= cls.imm_n;  state <= ST_IMM;
            end else emit = 1'b1;
          end
          ST_XDISP: begin
            disp_q <= in_byte;
            state  <= ST_XOP;
          end
          ST_DISP: begin
            disp_q <= in_byte;
            if (cls.imm_n != 2'd0) begin
              imm_left_q <= cls.imm_n;  state <= ST_IMM;
            end else emit = 1'b1;
          end
          ST_IMM: begin
            if (imm_left_q == 2'd1) emit = 1'b1;
            else begin
              imm_lo_q <= in_byte;  imm_pos_q <= 1'b1;  imm_left_q <= imm_left_q - 2'd1;
            end
          end
          default: emit = 1'b1;
        endcase
        if (emit) begin
          dec_valid <= 1'b1;  dec_kind <= cur_kind;  dec_op <= cur_op;
          dec_idx <= fin_idx;  dec_pfx_nop <= (pfx_q != IDX_NONE) && (fin_idx == IDX_NONE);
          dec_dst <= fin_dst;  dec_src <= fin_src;  dec_mem <= mem_any;
          dec_addr <= fin_addr;  dec_disp <= fin_disp;  dec_imm <= fin_imm;
          state <= ST_OP;  pfx_q <= IDX_NONE;  ext_q <= 1'b0;
        end
      end
    end
  end

  // Assertions next to the outputs they guard
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !dec_valid);
  assert_plain_codes_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_idx == IDX_NONE) |->
      ((dec_dst < 4'd8 || dec_dst == OPR_NONE) && (dec_src < 4'd8 || dec_src == OPR_NONE)));
  assert_x_codes_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_idx == IDX_X) |->
      !(dec_dst inside {4'd10, 4'd11, 4'd13}) && !(dec_src inside {4'd10, 4'd11, 4'd13}));
  assert_mem_keeps_hl_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == K_MAIN && (dec_dst inside {4'd12, 4'd13} || dec_src inside {4'd12, 4'd13}))
      |-> !(dec_dst inside {[4'd8:4'd11]}) && !(dec_src inside {[4'd8:4'd11]}));
  assert_nop_no_idx_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_pfx_nop) |-> dec_idx == IDX_NONE);
  assert_chain_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == K_PFX) |-> (dec_pfx_nop && (dec_op == PFX_X || dec_op == PFX_Y)));
  assert_bit_indexed_R9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == K_BIT && dec_idx != IDX_NONE) |-> (dec_mem && dec_src inside {4'd12, 4'd13}));
  assert_strobe_after_byte_R11: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid && in_ready));
endmodule

// File: tb/sim_idx_remap.sv
module sim_idx_remap;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, in_ready, dec_valid, dec_pfx_nop, dec_mem;
  logic [7:0] in_byte, dec_op, dec_disp;
  logic [15:0] hl_val, ix_val, iy_val, dec_addr, dec_imm;
  logic [1:0] dec_kind, dec_idx;
  logic [3:0] dec_dst, dec_src;

  idx_remap u0 (.*);

  logic [61:0] act_vec, got;
  logic        got_v;
  assign act_vec = {dec_kind, dec_op, dec_idx, dec_pfx_nop, dec_dst, dec_src,
                    dec_mem, dec_addr, dec_disp, dec_imm};

  int vecs = 0, miss = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      vecs++; miss++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [61:0] mk(input logic [1:0] k, input logic [7:0] op, input logic [1:0] ix,
      input logic nop, input logic [3:0] d, input logic [3:0] s, input logic m,
      input logic [15:0] ad, input logic [7:0] dp, input logic [15:0] im);
    return {k, op, ix, nop, d, s, m, ad, dp, im};
  endfunction

  function automatic logic [3:0] ecode(input logic [2:0] f, input int ix, input bit keep);
    if (ix == 0) return {1'b0, f};
    if (f == 3'd6) return 4'(11 + ix);
    if ((f == 3'd4 || f == 3'd5) && !keep) return 4'(6 + 2 * ix + int'(f) - 4);
    return {1'b0, f};
  endfunction

  function automatic logic [15:0] ebase(input int ix);
    return (ix == 1) ? ix_val : iy_val;
  endfunction

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got_v = dec_valid;
    got = act_vec;
  endtask

  task automatic send(input logic [7:0] s [0:5], input int n, input logic [61:0] e, input string tag);
    for (int i = 0; i < n; i++) begin
      put(s[i]);
      if (i < n - 1) chk(!got_v, tag, {63'b0, got_v}, 64'h0);
    end
    chk(got_v && got == e, tag, {1'b0, got_v, got}, {2'b01, e});
  endtask

  task automatic run_main(input logic [7:0] op, input int p);
    logic [7:0] s [0:5];
    int n = 0, k = 0, ixe;
    bit uy, uz, pr, touch, mem;
    logic [2:0] y = op[5:3], z = op[2:0];
    logic [1:0] x = op[7:6];
    logic [7:0] d = op ^ 8'h3C;
    logic [15:0] ad, im;
    string tag;
    uy = (x == 2'd1 && op != 8'h76) || (x == 2'd0 && z >= 3'd4 && z <= 3'd6);
    uz = (x == 2'd1 && op != 8'h76) || (x == 2'd2);
    pr = op inside {8'h09, 8'h19, 8'h29, 8'h39, 8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B,
                    8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9};
    if ((x == 0 && z == 0 && y >= 2) || (x == 0 && z == 6) || op == 8'hD3 || op == 8'hDB ||
        (x == 3 && z == 6)) k = 1;
    if ((x == 0 && z == 1 && !y[0]) || op inside {8'h22, 8'h2A, 8'h32, 8'h3A} ||
        (x == 3 && (z == 2 || z == 4)) || op == 8'hC3 || op == 8'hCD) k = 2;
    mem = (uy && y == 6) || (uz && z == 6);
    touch = pr || (uy && y inside {3'd4, 3'd5, 3'd6}) || (uz && z inside {3'd4, 3'd5, 3'd6});
    ixe = (p != 0 && touch) ? p : 0;
    if (p != 0) begin s[n] = (p == 1) ? 8'hDD : 8'hFD; n++; end
    s[n] = op; n++;
    if (ixe != 0 && mem) begin s[n] = d; n++; end
    if (k >= 1) begin s[n] = 8'h5A; n++; end
    if (k == 2) begin s[n] = 8'hC3; n++; end
    im = (k == 2) ? 16'hC35A : (k == 1) ? 16'h005A : 16'h0;
    ad = !mem ? 16'h0 : (ixe != 0) ? 16'(ebase(ixe) + {{8{d[7]}}, d}) : hl_val;
    tag = (p == 0) ? "R2 plain" : (!touch) ? "R5 dropped" : pr ? "R10 pair" :
          mem ? "R4/R7/R8 memory form" : "R3 halves";
    send(s, n, mk(2'd1, op, 2'(ixe), p != 0 && ixe == 0,
                  uy ? ecode(y, ixe, mem) : 4'd15, uz ? ecode(z, ixe, mem) : 4'd15,
                  mem, ad, (ixe != 0 && mem) ? d : 8'h00, im), tag);
  endtask

  task automatic run_bit(input logic [7:0] op, input int p);
    logic [7:0] s [0:5];
    int n = 0;
    logic [7:0] d = ~op;
    logic [2:0] z = op[2:0];
    logic [3:0] im = 4'(11 + p);
    if (p != 0) begin
      s[0] = (p == 1) ? 8'hDD : 8'hFD; s[1] = 8'hCB; s[2] = d; s[3] = op; n = 4;
      send(s, n, mk(2'd2, op, 2'(p), 1'b0, (z == 6) ? im : {1'b0, z}, im, 1'b1,
                    16'(ebase(p) + {{8{d[7]}}, d}), d, 16'h0), "R9 indexed bit page");
    end else begin
      s[0] = 8'hCB; s[1] = op; n = 2;
      send(s, n, mk(2'd2, op, 2'd0, 1'b0, {1'b0, z}, {1'b0, z}, z == 6,
                    (z == 6) ? hl_val : 16'h0, 8'h00, 16'h0), "R2 plain bit page");
    end
  endtask

  task automatic run_ext(input logic [7:0] op, input int p);
    logic [7:0] s [0:5];
    int n = 0;
    bit two = (op[7:6] == 2'b01 && op[2:0] == 3'b011);
    if (p != 0) begin s[n] = (p == 1) ? 8'hDD : 8'hFD; n++; end
    s[n] = 8'hED; n++;
    s[n] = op; n++;
    if (two) begin s[n] = 8'h5A; n++; s[n] = 8'hC3; n++; end
    send(s, n, mk(2'd3, op, 2'd0, p != 0, 4'd15, 4'd15, 1'b0, 16'h0, 8'h00,
                  two ? 16'hC35A : 16'h0), "R5/R12 extended page");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
    hl_val = 16'h4321; ix_val = 16'h1200; iy_val = 16'hFFC0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !dec_valid, "R1 reset", {62'b0, in_ready, dec_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !dec_valid, "R1 ready after reset", {62'b0, in_ready, dec_valid}, 64'h2);

    for (int op = 0; op < 256; op++)
      if (!(op inside {8'hDD, 8'hFD, 8'hCB, 8'hED}))
        for (int p = 0; p < 3; p++) run_main(8'(op), p);
    for (int op = 0; op < 256; op++)
      for (int p = 0; p < 3; p++) run_bit(8'(op), p);
    for (int op = 0; op < 256; op++)
      for (int p = 0; p < 2; p++) run_ext(8'(op), p * 2);

    // R6: chain DD FD DD then INC H
    put(8'hDD);
    chk(!got_v, "R6 first prefix silent", {63'b0, got_v}, 64'h0);
    put(8'hFD);
    chk(got_v && got == mk(2'd0, 8'hDD, 2'd0, 1'b1, 4'd15, 4'd15, 1'b0, 16'h0, 8'h0, 16'h0),
        "R6 dropped DD", {1'b0, got_v, got}, 64'h0);
    put(8'hDD);
    chk(got_v && got == mk(2'd0, 8'hFD, 2'd0, 1'b1, 4'd15, 4'd15, 1'b0, 16'h0, 8'h0, 16'h0),
        "R6 dropped FD", {1'b0, got_v, got}, 64'h0);
    put(8'h24);
    chk(got_v && got == mk(2'd1, 8'h24, 2'd1, 1'b0, 4'd8, 4'd15, 1'b0, 16'h0, 8'h0, 16'h0),
        "R6 last prefix wins", {1'b0, got_v, got}, 64'h0);
    // R11: strobe lasts one cycle
    @(negedge clk);
    chk(!dec_valid, "R11 one-cycle strobe", {63'b0, dec_valid}, 64'h0);

    // R6/R9: FD DD CB d 46 -> BIT 0,(X+d)
    put(8'hFD);
    put(8'hDD);
    chk(got_v && got[59:52] == 8'hFD, "R6 dropped before bit page", {1'b0, got_v, got}, 64'h0);
    put(8'hCB); put(8'hF0);
    chk(!got_v, "R9 displacement before opcode", {63'b0, got_v}, 64'h0);
    put(8'h46);
    chk(got_v && got == mk(2'd2, 8'h46, 2'd1, 1'b0, 4'd12, 4'd12, 1'b1, 16'h11F0, 8'hF0, 16'h0),
        "R9 chained bit", {1'b0, got_v, got}, 64'h0);

    // R11: prefix cleared after completion; next LD H,(HL) is plain
    put(8'h66);
    chk(got_v && got == mk(2'd1, 8'h66, 2'd0, 1'b0, 4'd4, 4'd6, 1'b1, 16'h4321, 8'h0, 16'h0),
        "R11 prefix cleared", {1'b0, got_v, got}, 64'h0);

    // R7: DD 36 d n
    put(8'hDD); put(8'h36); put(8'h85);
    chk(!got_v, "R7 immediate after displacement", {63'b0, got_v}, 64'h0);
    put(8'hA7);
    chk(got_v && got == mk(2'd1, 8'h36, 2'd1, 1'b0, 4'd12, 4'd15, 1'b1, 16'h1185, 8'h85, 16'h00A7),
        "R7 disp and imm", {1'b0, got_v, got}, 64'h0);

    // R8: address wrap over every displacement
    ix_val = 16'hFFF0; iy_val = 16'h0005;
    for (int d = 0; d < 256; d++) begin
      logic [7:0] s [0:5];
      logic [7:0] dd = 8'(d);
      s[0] = 8'hDD; s[1] = 8'h7E; s[2] = dd;
      send(s, 3, mk(2'd1, 8'h7E, 2'd1, 1'b0, 4'd7, 4'd12, 1'b1,
                    16'(32'hFFF0 + {{24{dd[7]}}, dd}), dd, 16'h0), "R8 wrap X");
      s[0] = 8'hFD; s[1] = 8'h74;
      send(s, 3, mk(2'd1, 8'h74, 2'd2, 1'b0, 4'd13, 4'd4, 1'b1,
                    16'(32'h0005 + {{24{dd[7]}}, dd}), dd, 16'h0), "R8 wrap Y, R4 keeps H");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule